// File: doc/BRIEF.md
# Debug-Link Sync Speed Measurer

This block is the host end of the speed-discovery step on a single-wire, open-drain debug link. When asked, it first pulls the shared line low for a long request, much longer than any low time that normal traffic uses. It then drives the line actively high for a short speedup pulse and releases it to high impedance. After that it waits for the target to answer with a low pulse. The target holds this pulse for exactly 128 of its own communication clock cycles.

The incoming line passes through a two-flop synchronizer. The block then times the response low phase in its own fast clock cycles. From that count it derives the length of one target cycle, rounded to the nearest fast cycle. The link protocol tolerates errors of several percent, so this precision is enough for the traffic that follows.

The block raises one of two flags at the end of a run. The done flag means the measurement is valid. The timeout flag means the target never answered, or held the line low for too long. The flag stays up until the next accepted start.

Top module: `dbg_sync_meter`

## Requirements
- R1: After reset `line_oe_o`, `busy_o`, `done_o` and `timeout_o` are 0, and `low_count_o` and `period_o` are 0.
- R2: A `start_i` pulse while idle makes the block drive the line low (`line_oe_o`=1, `line_do_o`=0) for exactly `REQ_LEN` clock cycles. During the whole run `busy_o` is 1.
- R3: Right after the request, the block drives the line high (`line_oe_o`=1, `line_do_o`=1) for exactly `SPD_LEN` cycles. It then releases the line (`line_oe_o`=0) and keeps it released until the run ends.
- R4: The first high-to-low transition of the synchronized line after release starts the measurement. When the line is seen high again, `done_o` rises and `low_count_o` equals the number of clock cycles the line was low.
- R5: When `done_o` rises, `period_o` equals (`low_count_o` + 64) / 128, rounded down. This is the target cycle length rounded to the nearest fast cycle.
- R6: If no falling edge arrives within `WAIT_MAX` cycles after release, `timeout_o` rises and `done_o` stays 0.
- R7: A low phase of exactly `LOW_MAX` cycles ends with `done_o`. A low phase of `LOW_MAX`+1 cycles ends with `timeout_o` instead. `done_o` and `timeout_o` are never 1 together.
- R8: `start_i` has no effect while `busy_o` is 1. `done_o` and `timeout_o` hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sync run (taken only when idle) |
| line_i | input | 1 | Raw level of the shared debug line |
| line_oe_o | output | 1 | Line drive enable (0 = high impedance) |
| line_do_o | output | 1 | Value driven when enabled |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Measurement valid, held until next start |
| timeout_o | output | 1 | No answer or over-long low, held until next start |
| low_count_o | output | CNT_W | Response low time in clock cycles |
| period_o | output | CNT_W | Rounded target cycle length in clock cycles |

## Verification
Two events can fall in the same cycle: the end of the response pulse, and the low counter reaching its limit. The bench provokes this by holding the target response low for exactly `LOW_MAX` cycles, and then for one cycle more. The first run must end with `done_o` and a count of `LOW_MAX`. The second must end with `timeout_o` and no done. Start requests during a busy run probe a second overlap, between a new request and an active phase. The bench judges it by the exact request length seen on the drive pins.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_SPD  = 3'd2,
    ST_WAIT = 3'd3,
    ST_LOW  = 3'd4
  } dsm_state_e;
endpackage

// File: rtl/dsm_line_sync.sv
module dsm_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
#(
  parameter int REQ_LEN  = 25600,
  parameter int SPD_LEN  = 1,
  parameter int WAIT_MAX = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic lvl_i,
  input  logic fall_i,
  input  logic low_full_i,
  output logic oe_o,
  output logic do_o,
  output logic busy_o,
  output logic done_o,
  output logic timeout_o,
  output logic low_start_o,
  output logic low_inc_o,
  output logic capture_o
);
  localparam int PH_MAX = (REQ_LEN > WAIT_MAX) ? REQ_LEN : WAIT_MAX;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  dsm_state_e state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic done_q, done_d, tmo_q, tmo_d;
  logic accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d     = state_q;
    ph_d        = ph_q;
    done_d      = done_q;
    tmo_d       = tmo_q;
    low_start_o = 1'b0;
    low_inc_o   = 1'b0;
    capture_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_REQ;
        ph_d    = '0;
        done_d  = 1'b0;
        tmo_d   = 1'b0;
      end
      ST_REQ: begin
        if (ph_q == PH_W'(REQ_LEN - 1)) begin
          state_d = ST_SPD;
          ph_d    = '0;
        end else ph_d = ph_q + 1'b1;
      end
      ST_SPD: begin
        if (ph_q == PH_W'(SPD_LEN - 1)) begin
          state_d = ST_WAIT;
          ph_d    = '0;
        end else ph_d = ph_q + 1'b1;
      end
      ST_WAIT: begin
        if (fall_i) begin
          state_d     = ST_LOW;
          low_start_o = 1'b1;
        end else if (ph_q == PH_W'(WAIT_MAX - 1)) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end else ph_d = ph_q + 1'b1;
      end
      ST_LOW: begin
        if (lvl_i) begin
          state_d   = ST_IDLE;
          done_d    = 1'b1;
          capture_o = 1'b1;
        end else if (low_full_i) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end else low_inc_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  assign oe_o      = (state_q == ST_REQ) || (state_q == ST_SPD);
  assign do_o      = (state_q == ST_SPD);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  // R2: every drive episode opens with the low request
  p_req_starts_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> !do_o);
  // R3: the line is only released after being driven high
  p_release_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> $past(do_o));
  // R7: the two end flags exclude each other
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));
  // R8: a start while busy does not restart the run
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !oe_o) |=> !oe_o);
endmodule

// File: rtl/dsm_low_timer.sv
module dsm_low_timer #(
  parameter int CNT_W   = 16,
  parameter int LOW_MAX = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_start_i,
  input  logic             low_inc_i,
  input  logic             capture_i,
  output logic             low_full_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] period_o
);
  localparam int          SHIFT = 7;
  localparam logic [CNT_W:0] HALF = (CNT_W + 1)'(1 << (SHIFT - 1));

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] res_q, per_q;
  logic [CNT_W:0]   rounded;

  always_comb begin
    cnt_d = cnt_q;
    if (low_start_i)    cnt_d = CNT_W'(1);
    else if (low_inc_i) cnt_d = cnt_q + 1'b1;
  end

  assign rounded    = ({1'b0, cnt_q} + HALF) >> SHIFT;
  assign low_full_o = (cnt_q == CNT_W'(LOW_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      res_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (capture_i) begin
        res_q <= cnt_q;
        per_q <= rounded[CNT_W-1:0];
      end
    end
  end

  assign count_o  = res_q;
  assign period_o = per_q;

  // R7: the live low counter never passes its limit
  p_low_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LOW_MAX));
  // R4: a captured measurement is never zero
  p_capture_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> count_o != '0);
endmodule

// File: rtl/dbg_sync_meter.sv
module dbg_sync_meter #(
  parameter int CNT_W    = 16,
  parameter int REQ_LEN  = 25600,
  parameter int SPD_LEN  = 1,
  parameter int WAIT_MAX = 4096,
  parameter int LOW_MAX  = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             line_i,
  output logic             line_oe_o,
  output logic             line_do_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] low_count_o,
  output logic [CNT_W-1:0] period_o
);
  logic lvl, fall, low_full, low_start, low_inc, capture;

  dsm_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .lvl_o(lvl), .fall_o(fall)
  );

  dsm_ctrl #(.REQ_LEN(REQ_LEN), .SPD_LEN(SPD_LEN), .WAIT_MAX(WAIT_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lvl_i(lvl), .fall_i(fall),
    .low_full_i(low_full), .oe_o(line_oe_o), .do_o(line_do_o), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .low_start_o(low_start),
    .low_inc_o(low_inc), .capture_o(capture)
  );

  dsm_low_timer #(.CNT_W(CNT_W), .LOW_MAX(LOW_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .low_start_i(low_start), .low_inc_i(low_inc),
    .capture_i(capture), .low_full_o(low_full), .count_o(low_count_o),
    .period_o(period_o)
  );

  // R1: nothing is driven while idle
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !line_oe_o);
endmodule

// File: tb/tb_dbg_sync_meter.sv
module tb_dbg_sync_meter;
  localparam int CNT_W    = 16;
  localparam int REQ_LEN  = 40;
  localparam int SPD_LEN  = 1;
  localparam int WAIT_MAX = 200;
  localparam int LOW_MAX  = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic tgt_low = 1'b0;
  logic line_oe_o, line_do_o, busy_o, done_o, timeout_o;
  logic [CNT_W-1:0] low_count_o, period_o;
  logic line_i;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  assign line_i = line_oe_o ? line_do_o : ~tgt_low;

  dbg_sync_meter #(.CNT_W(CNT_W), .REQ_LEN(REQ_LEN), .SPD_LEN(SPD_LEN),
                   .WAIT_MAX(WAIT_MAX), .LOW_MAX(LOW_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
    .line_oe_o(line_oe_o), .line_do_o(line_do_o), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .low_count_o(low_count_o),
    .period_o(period_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one sync; poke=1 pulses start during the request and low phases.
  task automatic run_sync(input int n, input bit respond, input bit poke,
                          output int req_c, output int spd_c);
    req_c = 0;
    spd_c = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < 100000; i++) begin
      start_i = poke && (req_c == 5);
      if (line_oe_o && !line_do_o) req_c++;
      else if (line_oe_o && line_do_o) spd_c++;
      else if (req_c + spd_c > 0) break;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (respond) begin
      repeat (15) @(negedge clk);
      tgt_low = 1'b1;
      for (int i = 0; i < n; i++) begin
        start_i = poke && (i == 3);
        @(negedge clk);
      end
      start_i = 1'b0;
      tgt_low = 1'b0;
    end
    for (int i = 0; i < 5000; i++) begin
      if (done_o || timeout_o) break;
      @(negedge clk);
    end
    tgt_low = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 oe", line_oe_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 timeout", timeout_o, 0);
    check("R1 count", low_count_o, 0);
    check("R1 period", period_o, 0);
  endtask

  task automatic t_measure(input int n, input int exp_per);
    int rc, sc;
    run_sync(n, 1'b1, 1'b0, rc, sc);
    check("R2 request length", rc, REQ_LEN);
    check("R3 speedup length", sc, SPD_LEN);
    check("R3 released", line_oe_o, 0);
    check("R4 done", done_o, 1);
    check("R4 count", low_count_o, n);
    check("R5 period", period_o, exp_per);
    check("R2 busy cleared", busy_o, 0);
  endtask

  task automatic t_no_answer();
    int rc, sc;
    run_sync(0, 1'b0, 1'b0, rc, sc);
    check("R6 timeout", timeout_o, 1);
    check("R6 no done", done_o, 0);
  endtask

  task automatic t_low_limit();
    int rc, sc;
    run_sync(LOW_MAX, 1'b1, 1'b0, rc, sc);
    check("R7 exact limit done", done_o, 1);
    check("R7 exact limit no timeout", timeout_o, 0);
    check("R7 exact limit count", low_count_o, LOW_MAX);
    run_sync(LOW_MAX + 1, 1'b1, 1'b0, rc, sc);
    check("R7 over limit timeout", timeout_o, 1);
    check("R7 over limit no done", done_o, 0);
  endtask

  task automatic t_busy_start();
    int rc, sc;
    run_sync(300, 1'b1, 1'b1, rc, sc);
    check("R8 request not restarted", rc, REQ_LEN);
    check("R8 count unaffected", low_count_o, 300);
    check("R8 done held", done_o, 1);
    repeat (20) @(negedge clk);
    check("R8 done still held", done_o, 1);
    run_sync(0, 1'b0, 1'b0, rc, sc);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R8 timeout cleared by start", timeout_o, 0);
    check("R8 done cleared by start", done_o, 0);
    repeat (REQ_LEN + WAIT_MAX + 20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_measure(256, 2);
    t_measure(191, 1);
    t_measure(192, 2);
    t_measure(1000, 8);
    t_no_answer();
    t_low_limit();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule